// File: doc/BRIEF.md
# Serial Flash Command Engine

This block runs one serial-flash transaction each time software asks for it. Software first loads a command word (command byte plus a 24-bit flash address) and a 32-bit data word. It then writes a control word holding a transmit byte count, a receive byte count, a clock divider choice and a start bit. The engine lowers chip select and clocks the requested bytes out in SPI mode 0. When the transmit bytes are done it clocks the receive bytes in while driving zeros. It then raises chip select and leaves the received bytes in the data word.

A busy flag in the control word stays set for the whole transaction. Software polls that flag before it touches the engine again. While the flag is set, writes to any register are dropped. The transmit count includes the command byte, so a single engine serves every transaction shape: a one-byte command, command plus address, command plus address plus up to four data bytes, or command followed by status or identification reads.

Top module: `spi_cmd_engine`

## Requirements
- R1: Registers sit at byte offsets 0x00 (control), 0x04 (command word) and 0x08 (data word), and are written with `reg_wr`. A read with `reg_rd` returns the addressed value on `reg_rdata` one clock later. The command and data words read back all 32 bits. The control word reads back the transmit count in [3:0], the receive count in [7:4], busy in [16] and the divider select in [25:24]. Bit 8 and all other bits read as 0, and so does any other offset.
- R2: A control write with bit 8 set starts a transaction of transmit+receive bytes. Busy (control bit 16) goes high on the same clock edge that captures the write. It stays high until one clock after chip select rises.
- R3: Chip select goes low on the edge that starts the transaction, one half SCK period before the first rising SCK edge. It stays low through every transmit and receive byte. It rises on the edge that ends the low half of the last bit.
- R4: SCK idles low. MOSI changes only while SCK is low, and MISO is sampled on the rising SCK edge. Every byte travels most significant bit first.
- R5: Transmit byte k is taken as follows. Byte 0 is command word [7:0]. Bytes 1, 2 and 3 are command word [31:24], [23:16] and [15:8]. Bytes 4 to 7 are data word [7:0], [15:8], [23:16] and [31:24]. Any transmit byte at position 8 or above is 0x00.
- R6: During the receive phase MOSI is 0. Receive byte j is placed in data word bits [8j+7:8j]. Bits above the received bytes read as zero. A receive count above 4 keeps only the first four bytes. The data word takes its new value on the edge where busy clears. A receive count of 0 leaves the data word unchanged.
- R7: Control bits [25:24] set the SCK period to 2, 4, 8 or 16 system clocks for the values 0, 1, 2 and 3. Each SCK half period lasts half of that.
- R8: While busy, a write to any register is ignored. In particular, a new start does not begin a transaction and does not change the stored counts or divider.
- R9: A start with transmit count plus receive count equal to zero updates the control fields but begins no transaction. Busy stays low and chip select stays high.
- R10: After a synchronous reset, chip select is high, SCK and MOSI are low, busy is low and all register fields read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The bench aims at the edges of the byte sequencing, using these transaction shapes:
- Receive counts of 1 and 2, where a design that failed to mask would leave stale upper bytes.
- A receive count of 6, where a design could let bytes wrap or overwrite slot 0.
- A transmit count of 12, where the bytes past the data word must be zero.
- A zero-length start, where a design might pulse chip select or hang busy.

It starts commands, and writes the command and data words, while busy. A design without the busy gate would restart or send corrupted bytes. All four divider settings are run. The pins are compared on every clock, so chip select rising one half period early or late is caught, and so is a bit sent LSB-first.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int CNT_W      = 4;
  localparam int BYTE_IDX_W = CNT_W + 1;
  localparam int DIV_SEL_W  = 2;
  localparam int WORD_W     = 32;

  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_CMD  = 4'h4;
  localparam logic [3:0] OFS_DATA = 4'h8;

  localparam int START_BIT = 8;
  localparam int BUSY_BIT  = 16;
  localparam int DIV_LSB   = 24;

  // Byte k of the outgoing stream; positions at or past the transmit count are zero.
  function automatic logic [7:0] tx_byte_pick(input logic [WORD_W-1:0] cmd_word,
                                               input logic [WORD_W-1:0] data_word,
                                               input logic [BYTE_IDX_W-1:0] idx,
                                               input logic [CNT_W-1:0] tx_cnt);
    logic [7:0] b;
    b = 8'h00;
    if (idx < {1'b0, tx_cnt}) begin
      case (idx)
        5'd0: b = cmd_word[7:0];
        5'd1: b = cmd_word[31:24];
        5'd2: b = cmd_word[23:16];
        5'd3: b = cmd_word[15:8];
        5'd4: b = data_word[7:0];
        5'd5: b = data_word[15:8];
        5'd6: b = data_word[23:16];
        5'd7: b = data_word[31:24];
        default: b = 8'h00;
      endcase
    end
    return b;
  endfunction
endpackage

// File: rtl/spi_sck_div.sv
module spi_sck_div #(
  parameter int DIV_SEL_W = spi_cmd_pkg::DIV_SEL_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic [DIV_SEL_W-1:0] div_sel,
  output logic                 tick
);
  localparam int CW = (1 << DIV_SEL_W) - 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] half_m1;

  always_comb begin
    half_m1 = CW'((32'd1 << div_sel) - 32'd1);
    tick    = run && (cnt_q == half_m1);
  end

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [BITS-1:0] load_byte,
  input  logic            shift,
  input  logic            rise,
  input  logic            miso,
  output logic            mosi,
  output logic [BITS-1:0] rx_byte
);
  logic [BITS-1:0] tx_q;
  logic [BITS-1:0] rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load)       tx_q <= load_byte;
      else if (shift) tx_q <= {tx_q[BITS-2:0], 1'b0};
      if (rise)       rx_q <= {rx_q[BITS-2:0], miso};
    end
  end

  assign mosi    = tx_q[BITS-1];
  assign rx_byte = rx_q;
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq #(
  parameter int CNT_W = spi_cmd_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic [CNT_W-1:0] rx_cnt,
  input  logic             tick,
  output logic             active,
  output logic             sck,
  output logic             cs_n,
  output logic             busy,
  output logic             done,
  output logic             rise,
  output logic             shift,
  output logic             load,
  output logic [CNT_W:0]   load_idx,
  output logic             rx_store,
  output logic [1:0]       rx_slot
);
  localparam int BW = CNT_W + 1;

  logic          active_q, sck_q, cs_n_q, busy_q, fin_q;
  logic [2:0]    bit_q;
  logic [BW-1:0] byte_q;
  logic [BW-1:0] total;
  logic [BW-1:0] rx_off;
  logic          fall, last_bit, last_byte;

  always_comb begin
    total     = {1'b0, tx_cnt} + {1'b0, rx_cnt};
    fall      = tick && active_q && sck_q;
    rise      = tick && active_q && !sck_q;
    last_bit  = (bit_q == 3'd7);
    last_byte = (byte_q == total - 1'b1);
    rx_off    = byte_q - {1'b0, tx_cnt};
    shift     = fall && !last_bit;
    load      = go || (fall && last_bit);
    load_idx  = go ? '0 : byte_q + 1'b1;
    rx_store  = fall && last_bit && (byte_q >= {1'b0, tx_cnt}) && (rx_off < BW'(4));
    rx_slot   = rx_off[1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      cs_n_q   <= 1'b1;
      busy_q   <= 1'b0;
      fin_q    <= 1'b0;
      bit_q    <= '0;
      byte_q   <= '0;
    end else begin
      fin_q <= 1'b0;
      if (go) begin
        active_q <= 1'b1;
        cs_n_q   <= 1'b0;
        sck_q    <= 1'b0;
        busy_q   <= 1'b1;
        bit_q    <= '0;
        byte_q   <= '0;
      end else if (fin_q) begin
        busy_q <= 1'b0;
      end else if (rise) begin
        sck_q <= 1'b1;
      end else if (fall) begin
        sck_q <= 1'b0;
        if (last_bit) begin
          bit_q <= '0;
          if (last_byte) begin
            active_q <= 1'b0;
            cs_n_q   <= 1'b1;
            fin_q    <= 1'b1;
          end else begin
            byte_q <= byte_q + 1'b1;
          end
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end

  assign active = active_q;
  assign sck    = sck_q;
  assign cs_n   = cs_n_q;
  assign busy   = busy_q;
  assign done   = fin_q;
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CNT_W_P   = CNT_W,
  parameter int DIV_W_P   = DIV_SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int BW = CNT_W_P + 1;

  logic [CNT_W_P-1:0] tx_cnt_q, rx_cnt_q;
  logic [DIV_W_P-1:0] div_q;
  logic [31:0]        cmd_q, data_q, acc_q, rdata_q, ctrl_view;

  logic          seq_active, seq_busy, seq_done, seq_rise, seq_shift, seq_load;
  logic          seq_store, tick;
  logic [1:0]    seq_slot;
  logic [BW-1:0] seq_idx;
  logic [7:0]    rx_byte, load_byte;
  logic          wr_ctrl, wr_cmd, wr_data, go;
  logic [CNT_W_P-1:0] new_tx, new_rx, pick_tx;

  always_comb begin
    new_tx  = reg_wdata[CNT_W_P-1:0];
    new_rx  = reg_wdata[2*CNT_W_P-1:CNT_W_P];
    wr_ctrl = reg_wr && !seq_busy && (reg_addr == ADDR_W'(OFS_CTRL));
    wr_cmd  = reg_wr && !seq_busy && (reg_addr == ADDR_W'(OFS_CMD));
    wr_data = reg_wr && !seq_busy && (reg_addr == ADDR_W'(OFS_DATA));
    go      = wr_ctrl && reg_wdata[START_BIT] && (({1'b0, new_tx} + {1'b0, new_rx}) != '0);
    pick_tx = go ? new_tx : tx_cnt_q;
    load_byte = tx_byte_pick(cmd_q, data_q, seq_idx, pick_tx);
  end

  spi_sck_div #(.DIV_SEL_W(DIV_W_P)) u_div (
    .clk(clk), .rst(rst), .run(seq_active), .div_sel(div_q), .tick(tick)
  );

  spi_cmd_seq #(.CNT_W(CNT_W_P)) u_seq (
    .clk(clk), .rst(rst), .go(go), .tx_cnt(tx_cnt_q), .rx_cnt(rx_cnt_q),
    .tick(tick), .active(seq_active), .sck(spi_sck), .cs_n(spi_cs_n),
    .busy(seq_busy), .done(seq_done), .rise(seq_rise), .shift(seq_shift),
    .load(seq_load), .load_idx(seq_idx), .rx_store(seq_store), .rx_slot(seq_slot)
  );

  spi_bit_shifter #(.BITS(8)) u_shift (
    .clk(clk), .rst(rst), .load(seq_load), .load_byte(load_byte),
    .shift(seq_shift), .rise(seq_rise), .miso(spi_miso),
    .mosi(spi_mosi), .rx_byte(rx_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_cnt_q <= '0;
      rx_cnt_q <= '0;
      div_q    <= '0;
      cmd_q    <= '0;
      data_q   <= '0;
      acc_q    <= '0;
    end else begin
      if (wr_ctrl) begin
        tx_cnt_q <= new_tx;
        rx_cnt_q <= new_rx;
        div_q    <= reg_wdata[DIV_LSB +: DIV_W_P];
      end
      if (wr_cmd) cmd_q <= reg_wdata;
      if (go)             acc_q <= '0;
      else if (seq_store) acc_q[8*seq_slot +: 8] <= rx_byte;
      if (wr_data)                                data_q <= reg_wdata;
      else if (seq_done && (rx_cnt_q != '0))      data_q <= acc_q;
    end
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CNT_W_P-1:0]         = tx_cnt_q;
    ctrl_view[2*CNT_W_P-1:CNT_W_P] = rx_cnt_q;
    ctrl_view[BUSY_BIT]            = seq_busy;
    ctrl_view[DIV_LSB +: DIV_W_P]  = div_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (reg_rd) begin
      if (reg_addr == ADDR_W'(OFS_CTRL))      rdata_q <= ctrl_view;
      else if (reg_addr == ADDR_W'(OFS_CMD))  rdata_q <= cmd_q;
      else if (reg_addr == ADDR_W'(OFS_DATA)) rdata_q <= data_q;
      else                                    rdata_q <= '0;
    end
  end

  assign reg_rdata = rdata_q;
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk (
  input logic        clk,
  input logic        rst,
  input logic        cs_n,
  input logic        sck,
  input logic        mosi,
  input logic        busy,
  input logic        wr,
  input logic [3:0]  addr,
  input logic [31:0] wdata,
  input logic [3:0]  tx_cnt
);
  assert_sck_in_frame_R3: assert property (@(posedge clk) disable iff (rst)
    sck |-> !cs_n);

  assert_busy_tail_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> busy ##1 !busy);

  assert_idle_pins_R10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cs_n && !sck && !mosi));

  assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (sck && $past(sck)) |-> $stable(mosi));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && wr && addr == 4'h0) |=> $stable(tx_cnt));

  assert_zero_len_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && wr && addr == 4'h0 && wdata[8] && wdata[7:0] == 8'h00) |=> (!busy && cs_n));
endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi),
  .busy(seq_busy), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .tx_cnt(tx_cnt_q)
);

// File: tb/sim_spi_cmd_engine.sv
`timescale 1ns/1ps
module sim_spi_cmd_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_cs_n, spi_sck, spi_mosi, spi_miso;

  always #2.5 clk = ~clk;

  spi_cmd_engine u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int total = 0, bad = 0, cyc = 0;
  bit live = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // flash-side responder: stream bit i is resp[i], advanced on each rising SCK
  logic [255:0] resp = '0;
  int scnt = 0;
  always @(posedge spi_sck or posedge spi_cs_n) begin
    if (spi_cs_n) scnt <= 0;
    else          scnt <= scnt + 1;
  end
  assign spi_miso = (scnt < 256) ? resp[scnt] : 1'b0;

  // behavioural reference
  bit          m_busy;
  int          m_t, m_h, m_n;
  logic [3:0]  m_tx, m_rx, s_tx, s_rx;
  logic [1:0]  m_div;
  logic [31:0] m_cmd, m_data, s_cmd, s_data;

  function automatic logic [7:0] ref_byte(input int i);
    if (i >= s_tx) return 8'h00;
    case (i)
      0: return s_cmd[7:0];
      1: return s_cmd[31:24];
      2: return s_cmd[23:16];
      3: return s_cmd[15:8];
      4: return s_data[7:0];
      5: return s_data[15:8];
      6: return s_data[23:16];
      7: return s_data[31:24];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [31:0] ref_rx();
    logic [31:0] v = '0;
    int n = (s_rx > 4) ? 4 : int'(s_rx);
    for (int j = 0; j < n; j++)
      for (int k = 0; k < 8; k++)
        v[j*8 + 7 - k] = resp[(int'(s_tx) + j) * 8 + k];
    return v;
  endfunction

  function automatic logic [31:0] ref_reg(input logic [3:0] a);
    logic [31:0] v = '0;
    case (a)
      4'h0: begin v[3:0] = m_tx; v[7:4] = m_rx; v[16] = m_busy; v[25:24] = m_div; end
      4'h4: v = m_cmd;
      4'h8: v = m_data;
      default: v = '0;
    endcase
    return v;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_busy = 0; m_t = 0; m_h = 1; m_n = 0;
      m_tx = 0; m_rx = 0; m_div = 0; m_cmd = 0; m_data = 0;
      s_tx = 0; s_rx = 0; s_cmd = 0; s_data = 0;
    end else begin
      automatic bit was = m_busy;
      if (m_busy) begin
        m_t++;
        if (m_t == 2 * m_n * m_h + 1) begin
          m_busy = 0;
          if (s_rx != 0) m_data = ref_rx();
        end
      end
      if (reg_wr && !was) begin
        case (reg_addr)
          4'h0: begin
            m_tx = reg_wdata[3:0]; m_rx = reg_wdata[7:4]; m_div = reg_wdata[25:24];
            if (reg_wdata[8] && (int'(m_tx) + int'(m_rx)) != 0) begin
              m_busy = 1; m_t = 0; m_h = 1 << m_div; m_n = 8 * (int'(m_tx) + int'(m_rx));
              s_tx = m_tx; s_rx = m_rx; s_cmd = m_cmd; s_data = m_data;
            end
          end
          4'h4: m_cmd = reg_wdata;
          4'h8: m_data = reg_wdata;
          default: ;
        endcase
      end
    end
  end

  // pin comparison on every clock
  always @(negedge clk) begin
    if (live) begin
      logic ecs, esck, emosi;
      ecs = 1; esck = 0; emosi = 0;
      if (m_busy) begin
        automatic int k = m_t / m_h;
        if (k < 2 * m_n) begin
          automatic int b = k / 2;
          automatic logic [7:0] by = ref_byte(b / 8);
          ecs = 0; esck = k[0]; emosi = by[7 - (b % 8)];
        end
      end
      chk("R3", "cs_n", {31'b0, spi_cs_n}, {31'b0, ecs});
      chk("R7", "sck", {31'b0, spi_sck}, {31'b0, esck});
      chk("R5", "mosi", {31'b0, spi_mosi}, {31'b0, emosi});
    end
  end

  always @(posedge clk) begin
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, input string req);
    logic [31:0] e;
    @(negedge clk); reg_rd = 1; reg_addr = a; e = ref_reg(a);
    @(negedge clk); reg_rd = 0;
    chk(req, $sformatf("read @%h", a), reg_rdata, e);
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic cmd(input logic [31:0] c, input logic [31:0] d, input logic [3:0] tx,
                     input logic [3:0] rx, input logic [1:0] dv, input logic [255:0] r, input string req);
    wr(4'h4, c);
    wr(4'h8, d);
    resp = r;
    wr(4'h0, {6'b0, dv, 15'b0, 1'b1, rx, tx});
    rd(4'h0, "R2");
    wait_idle();
    rd(4'h8, req);
    rd(4'h0, "R2");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    live = 1;
    // R10 reset state
    chk("R10", "cs_n", {31'b0, spi_cs_n}, 32'd1);
    chk("R10", "sck", {31'b0, spi_sck}, 32'd0);
    chk("R10", "mosi", {31'b0, spi_mosi}, 32'd0);
    rd(4'h0, "R10"); rd(4'h4, "R10"); rd(4'h8, "R10");
    // R1 readback
    wr(4'h4, 32'hA5C3_0F12); wr(4'h8, 32'h1234_5678);
    rd(4'h4, "R1"); rd(4'h8, "R1"); rd(4'hC, "R1");
    wr(4'h0, 32'h0300_0021); rd(4'h0, "R1");
    // R6 single receive byte masked
    cmd(32'h0000_00AB, 32'hFFFF_FFFF, 4'd4, 4'd1, 2'd0, {8{32'h9D3C_5AE1}}, "R6");
    // R5 program with four data bytes, no receive: data unchanged
    cmd(32'h1234_5602, 32'hDEAD_BEEF, 4'd8, 4'd0, 2'd1, {8{32'h0F0F_3355}}, "R5");
    // R7 slowest divider, full word receive
    cmd(32'h00AB_CD03, 32'h0, 4'd4, 4'd4, 2'd3, {8{32'hC1A7_6E29}}, "R7");
    // R4 two status bytes, divider 8
    cmd(32'h0000_0005, 32'h0, 4'd1, 4'd2, 2'd2, {8{32'h5B71_C4E8}}, "R4");
    // R5 transmit count beyond data word sends zeros
    cmd(32'h7766_5544, 32'h0BAD_F00D, 4'd12, 4'd0, 2'd0, '0, "R5");
    // R6 receive count above four keeps first four
    cmd(32'h0102_0303, 32'h0, 4'd4, 4'd6, 2'd0, {8{32'h3E94_B617}}, "R6");
    // R3 single opcode
    cmd(32'h0000_0006, 32'h0, 4'd1, 4'd0, 2'd1, '0, "R3");
    // R8 writes while busy are dropped
    wr(4'h4, 32'h00FE_DC03); resp = {8{32'h6A2D_91F0}};
    wr(4'h0, 32'h0300_0144);
    repeat (5) @(negedge clk);
    wr(4'h0, 32'h0000_0111);
    wr(4'h4, 32'h1111_1111);
    wr(4'h8, 32'h2222_2222);
    rd(4'h0, "R8");
    wait_idle();
    rd(4'h0, "R8"); rd(4'h4, "R8"); rd(4'h8, "R8");
    // R9 zero-length start
    wr(4'h0, 32'h0200_0100);
    rd(4'h0, "R9");
    chk("R9", "cs_n idle", {31'b0, spi_cs_n}, 32'd1);
    repeat (10) @(negedge clk);
    chk("R9", "cs_n still idle", {31'b0, spi_cs_n}, 32'd1);
    rd(4'h8, "R9");
    live = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule